// File: doc/BRIEF.md
# Serial Test Control Register with Single-Stage Bypass

This block holds the static test settings for the logic of one core. Settings are shifted in serially through a shift register. A pulse on the update input then copies them into a shadow register that drives the control outputs. As a result, the outputs never move while new data is passing through. A decoder turns the shadow contents into one scan-enable output, which can take one of four kinds of behaviour, and a small set of single-bit flags.

The enable input is active low for reset, and the reset is asynchronous. While reset is active, the controlled logic is forced into functional operation. The shift stages are also preloaded with a per-instance opcode: a self-test opcode for cores that own BIST hardware, and an idle opcode for all other cores. When reset is released, the shadow register holds the idle mode. For a core that owns BIST hardware, a bare update then starts self-test.

An extra bypass shift stage sits at the serial output, paired with a bypass update stage. When the bypass update stage holds 0, the main register is skipped, so the serial path through this block is one stage long. In that state, updates to the shadow register are blocked, so the core keeps its settings while other registers in a long chain are loaded.

Top module: `test_ctrl_reg`

## Requirements
- R1: While `tc_en` is low, `scan_en_o`, `flag_o` and `bist_run_o` are all 0, whatever the other inputs are.
- R2: While `tc_en` is low, the bypass shift stage is set to 1 and the main shift stages are set to `RUNBIST_OP` when `USE_BIST` is 1, or to `IDLE_OP` otherwise. Shifting then presents the bypass stage first at `so`, followed by main bit 0, bit 1 and so on.
- R3: After `tc_en` rises, the outputs decode `IDLE_OP` until the first update, and `bist_run_o` is 0.
- R4: Serial data enters at the top main bit and moves toward bit 0, then into the bypass stage. The outputs change only on the clock edge that samples `upd_i`, never during shifting.
- R5: Shadow bits [1:0] select the scan-enable kind: 00 gives constant 0, 01 gives constant 1, 10 follows `se_i`, and 11 gives the inverse of `se_i`. `flag_o[i]` equals shadow bit i+2.
- R6: With `USE_BIST` set, an update that comes before any shift since reset release sets `bist_run_o`. Any shift cycle removes that right. Any later update that reaches the shadow register clears `bist_run_o`. With `USE_BIST` clear, `bist_run_o` stays 0.
- R7: While `hold_i` is high, shift requests are ignored: the main and bypass shift stages and `so` keep their values.
- R8: While the bypass update stage is 0, the bypass shift stage captures `si` directly, so the serial path is one stage long.
- R9: An update while the bypass update stage is 0 leaves the outputs unchanged. This includes the update that turns the bypass off.
- R10: The bypass update stage resets to 1 and takes the value of the bypass shift stage on every update.
- R11: `so` is the bypass shift stage re-timed on the falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| tc_en | input | 1 | Test enable; low is an asynchronous reset to functional mode |
| se_i | input | 1 | Scan-shift level used by scan-enable kinds 10 and 11 |
| si | input | 1 | Serial data in |
| shift_i | input | 1 | Shift request |
| upd_i | input | 1 | One-cycle update pulse |
| hold_i | input | 1 | Freezes the shift stages |
| so | output | 1 | Serial data out, falling-edge re-timed |
| scan_en_o | output | 1 | Decoded scan-enable control |
| flag_o | output | N_FLAG | Static single-bit test controls |
| bist_run_o | output | 1 | Self-test run indication |

## Verification
Several properties are checked on every cycle:
- The outputs are forced to functional values during reset.
- The flags stay still between updates.
- The shadow register stays frozen in bypass.
- The bypass stage captures `si` in bypass.
- Hold keeps the shift stages.
- `bist_run_o` rises only on an update.

Some behaviours can only be shown by the bench's scenarios:
- The exact serial order of the preloaded opcode at `so`.
- The decoding of every scan-enable kind against `se_i`.
- The rule that any shift since reset removes the right to start self-test.
- The masked update that turns the bypass off.
- The falling-edge timing of `so`.

// File: rtl/test_ctrl_reg.sv
module test_ctrl_reg #(
  parameter int N_FLAG = 4,
  parameter bit USE_BIST = 1'b1,
  parameter logic [N_FLAG+1:0] IDLE_OP = 6'b000100,
  parameter logic [N_FLAG+1:0] RUNBIST_OP = 6'b110100
) (
  input  logic              clk,
  input  logic              tc_en,
  input  logic              se_i,
  input  logic              si,
  input  logic              shift_i,
  input  logic              upd_i,
  input  logic              hold_i,
  output logic              so,
  output logic              scan_en_o,
  output logic [N_FLAG-1:0] flag_o,
  output logic              bist_run_o
);
  localparam int W = N_FLAG + 2;
  localparam logic [W-1:0] PRELOAD = USE_BIST ? RUNBIST_OP : IDLE_OP;

  logic [W-1:0] sh_q, up_q;
  logic bs_q, bu_q, fresh_q, run_q, so_q, kind_val;

  wire do_shift = shift_i & ~hold_i;
  wire bs_d = bu_q ? sh_q[0] : si;

  always_ff @(posedge clk or negedge tc_en) begin
    if (!tc_en) begin
      sh_q    <= PRELOAD;
      bs_q    <= 1'b1;
      bu_q    <= 1'b1;
      up_q    <= IDLE_OP;
      fresh_q <= 1'b1;
      run_q   <= 1'b0;
    end else begin
      if (do_shift) begin
        sh_q    <= {si, sh_q[W-1:1]};
        bs_q    <= bs_d;
        fresh_q <= 1'b0;
      end
      if (upd_i) begin
        bu_q <= bs_q;
        if (bu_q) begin
          up_q  <= sh_q;
          run_q <= USE_BIST & fresh_q;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge tc_en) begin
    if (!tc_en) so_q <= 1'b1;
    else        so_q <= bs_q;
  end
  assign so = so_q;

  always_comb begin
    case (up_q[1:0])
      2'b00:   kind_val = 1'b0;
      2'b01:   kind_val = 1'b1;
      2'b10:   kind_val = se_i;
      default: kind_val = ~se_i;
    endcase
  end

  assign scan_en_o  = tc_en & kind_val;
  assign flag_o     = tc_en ? up_q[W-1:2] : '0;
  assign bist_run_o = tc_en & run_q;

  always @(posedge clk) begin
    if (!tc_en) begin
      assert_functional_R1: assert (!scan_en_o && flag_o == '0 && !bist_run_o);
    end
  end

  assert_flags_still_R4: assert property (@(posedge clk) disable iff (!tc_en)
    !upd_i |=> $stable(flag_o));

  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!tc_en)
    hold_i |=> $stable(sh_q) && $stable(bs_q));

  assert_bypass_path_R8: assert property (@(posedge clk) disable iff (!tc_en)
    (!bu_q && do_shift) |=> bs_q == $past(si));

  assert_bypass_freeze_R9: assert property (@(posedge clk) disable iff (!tc_en)
    (!bu_q && upd_i) |=> $stable(up_q));

  assert_bu_capture_R10: assert property (@(posedge clk) disable iff (!tc_en)
    upd_i |=> bu_q == $past(bs_q));

  assert_bist_on_update_R6: assert property (@(posedge clk) disable iff (!tc_en)
    $rose(run_q) |-> $past(upd_i) && $past(fresh_q));
endmodule

// File: tb/test_test_ctrl_reg.sv
module test_test_ctrl_reg;
  localparam int N_FLAG = 4;
  localparam int W = N_FLAG + 2;
  localparam logic [W-1:0] IDLE = 6'b000100;
  localparam logic [W-1:0] RUNB = 6'b110100;
  localparam logic [6:0] VEC [0:7] = '{
    7'b0_000000, 7'b1_000001, 7'b1_111110, 7'b0_101010,
    7'b0_010111, 7'b1_100011, 7'b0_011101, 7'b1_110100};

  logic clk = 0, tc_en = 0, se_i = 0, si = 0, shift_i = 0, upd_i = 0, hold_i = 0;
  logic so_a, scan_a, run_a, so_b, scan_b, run_b;
  logic [N_FLAG-1:0] flag_a, flag_b;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  test_ctrl_reg #(.N_FLAG(N_FLAG), .USE_BIST(1'b1), .IDLE_OP(IDLE), .RUNBIST_OP(RUNB)) i_test_ctrl_reg (
    .clk(clk), .tc_en(tc_en), .se_i(se_i), .si(si), .shift_i(shift_i), .upd_i(upd_i),
    .hold_i(hold_i), .so(so_a), .scan_en_o(scan_a), .flag_o(flag_a), .bist_run_o(run_a));

  test_ctrl_reg #(.N_FLAG(N_FLAG), .USE_BIST(1'b0), .IDLE_OP(IDLE), .RUNBIST_OP(RUNB)) i_test_ctrl_reg_idle (
    .clk(clk), .tc_en(tc_en), .se_i(se_i), .si(si), .shift_i(shift_i), .upd_i(upd_i),
    .hold_i(hold_i), .so(so_b), .scan_en_o(scan_b), .flag_o(flag_b), .bist_run_o(run_b));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic exp_scan(input logic [1:0] k, input logic se);
    case (k)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return se;
      default: return ~se;
    endcase
  endfunction

  task automatic step(input logic s, input logic u, input logic h, input logic d);
    shift_i = s; upd_i = u; hold_i = h; si = d;
    @(posedge clk); #1;
    shift_i = 0; upd_i = 0; hold_i = 0; si = 0;
  endtask

  task automatic shift_op(input logic [W-1:0] op, input logic bsbit);
    step(1, 0, 0, bsbit);
    for (int i = 0; i < W; i++) step(1, 0, 0, op[i]);
  endtask

  task automatic do_reset();
    tc_en = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic release_rst();
    tc_en = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N_FLAG-1:0] prev;
    se_i = 1;
    do_reset();
    // R1: functional values while reset is active
    chk("R1 scan", scan_a, 0); chk("R1 flags", flag_a, 0); chk("R1 run", run_a, 0);
    chk("R1 flags idle inst", flag_b, 0);
    step(1, 1, 0, 1);
    chk("R1 ignore ctrl in reset", {scan_a, flag_a, run_a}, 0);
    se_i = 0;
    release_rst();
    // R3: idle mode after release
    chk("R3 flags", flag_a, IDLE[W-1:2]); chk("R3 scan", scan_a, exp_scan(IDLE[1:0], 0));
    chk("R3 run", run_a, 0); chk("R3 flags idle inst", flag_b, IDLE[W-1:2]);
    // R6: bare update starts self-test
    step(0, 1, 0, 0);
    chk("R6 run set", run_a, 1); chk("R6 flags runbist", flag_a, RUNB[W-1:2]);
    chk("R6 idle inst no run", run_b, 0); chk("R6 idle inst flags", flag_b, IDLE[W-1:2]);
    shift_op(6'b000100, 1'b1);
    chk("R6 run kept while shifting", run_a, 1);
    step(0, 1, 0, 0);
    chk("R6 run cleared", run_a, 0); chk("R6 flags after bist", flag_a, 4'b0001);

    // R6: a shift before the update removes the self-test start
    do_reset(); release_rst();
    shift_op(RUNB, 1'b1);
    step(0, 1, 0, 0);
    chk("R6 no run after shift", run_a, 0); chk("R6 flags loaded", flag_a, RUNB[W-1:2]);

    // R2 / R11: preload order at so
    do_reset(); release_rst();
    chk("R2 bs preload", so_a, 1);
    for (int k = 0; k < W; k++) begin
      step(1, 0, 0, 0);
      @(negedge clk); #1;
      chk("R2 preload bit", so_a, RUNB[k]);
      chk("R2 preload bit idle inst", so_b, IDLE[k]);
    end

    // R4 / R5: vector table
    prev = flag_a;
    for (int v = 0; v < 8; v++) begin
      shift_op(VEC[v][5:0], 1'b1);
      chk("R4 no change while shifting", flag_a, prev);
      step(0, 1, 0, 0);
      se_i = VEC[v][6]; #1;
      chk("R5 flags", flag_a, VEC[v][5:2]);
      chk("R5 scan kind", scan_a, exp_scan(VEC[v][1:0], VEC[v][6]));
      se_i = ~se_i; #1;
      chk("R5 scan kind other se", scan_a, exp_scan(VEC[v][1:0], se_i));
      prev = flag_a;
    end
    se_i = 0;

    // R7: hold interleaved with shifting
    step(1, 0, 0, 1);
    @(negedge clk); #1;
    prev[0] = so_a;
    step(1, 0, 1, 0);
    @(negedge clk); #1;
    chk("R7 so held", so_a, prev[0]);
    for (int i = 0; i < W; i++) begin
      step(1, 0, 1, ~VEC[3][i]);
      step(1, 0, 0, VEC[3][i]);
    end
    step(0, 1, 0, 0);
    chk("R7 hold ignored", flag_a, VEC[3][5:2]);

    // R10 / R8 / R9 / R11: bypass
    shift_op(6'b100110, 1'b0);
    step(0, 1, 0, 0);
    chk("R10 update loads before bypass", flag_a, 4'b1001);
    step(1, 0, 0, 1);
    chk("R11 so before falling edge", so_a, 0);
    @(negedge clk); #1;
    chk("R8 single stage 1", so_a, 1);
    step(1, 0, 0, 0);
    @(negedge clk); #1;
    chk("R8 single stage 0", so_a, 0);
    step(1, 0, 0, 1);
    @(negedge clk); #1;
    chk("R8 single stage 1b", so_a, 1);
    step(1, 0, 0, 0);
    step(0, 1, 0, 0);
    chk("R9 frozen in bypass", flag_a, 4'b1001);
    step(1, 0, 0, 1);
    step(0, 1, 0, 0);
    chk("R9 masked turn-off update", flag_a, 4'b1001);
    shift_op(6'b001100, 1'b1);
    step(0, 1, 0, 0);
    chk("R10 bypass off loads", flag_a, 4'b0011);
    chk("R10 scan after bypass", scan_a, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule